// File: doc/BRIEF.md
# Synchronous Modulated-Light Presence Detector

This block decides whether an object sits in front of each of several reflective optical sensors. The emitters of these sensors are driven with a square-wave reference that the block generates itself. A sensor sees its own emitter only when an object reflects the light back. The block therefore trusts a sensor only while the sensor's sampled level follows the reference. Steady ambient light, darkness, lamp flicker and fast electrical noise do not follow the reference, so they never qualify.

Each channel passes its sensor bit through a synchroniser. The reference goes through a synchroniser of the same depth, so both reach the compare point aligned. A small state machine counts consecutive agreeing samples in state `QS_SEEK`. On the agreement that completes four full reference periods it takes the *qualify* transition to `QS_PRESENT`. A mismatch in `QS_SEEK` takes the *restart* transition: the count returns to zero and the state stays in `QS_SEEK`. In `QS_PRESENT` the counter is frozen and the flag stays high until a mismatch event takes the *release* transition back to `QS_SEEK`. An optional filter can require a mismatch to persist for several samples before it counts as an event.

Top module: `presdet_top`

## Requirements
- R1: `emit_o` is the base clock divided by eight. It is 0 after reset, changes only on a falling edge of `clk`, and holds each level for exactly four base-clock periods.
- R2: While reset is asserted and right after it, every bit of `present_o` is 0.
- R3: A sensor bit and the reference pass through the same number of rising-edge stages (two by default). A sample agrees when the two delayed bits are equal. With a sensor that echoes `emit_o`, every sample agrees.
- R4: A channel's `present_o` bit rises on the rising edge that takes in its 32nd consecutive agreeing sample, 4 reference periods × 8 samples. Seen from the ports, this is two rising edges after the 32nd agreeing `sense_i` sample.
- R5: Once high, a channel's `present_o` bit stays high for as long as its samples agree.
- R6: With the filter off, `present_o` falls on the rising edge that takes in the first mismatching sample.
- R7: A mismatch before the threshold restarts the agreement count from zero.
- R8: A sensor bit that is stuck at 1, stuck at 0, toggling every base-clock cycle or inverted from the reference never sets its `present_o` bit.
- R9: The channels are independent: one channel's input never changes another channel's flag.
- R10: Parameter `MIN_MISMATCH` (default 1, filter off) is the number of consecutive mismatching samples needed for a mismatch event. With 2, a one-sample glitch neither clears a present flag nor restarts the count, while a two-sample mismatch does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; divider on falling edge, sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_i | input | CHANNELS | Asynchronous sensor levels, 1 = light received |
| emit_o | output | 1 | Reference square wave that drives the emitters |
| present_o | output | CHANNELS | Qualified presence flag per channel |

## Verification
The hardest situation to reach is a mismatch landing just before the 32nd agreement, or a single-sample glitch while a flag is latched. A sensor held low mismatches only on the reference's high half, so random timing rarely hits these cases exactly. The bench therefore derives each sensor input from `emit_o` and inverts it for exactly one or two base-clock samples at chosen points. These targeted glitches are mixed with random mode changes (echo, stuck, toggling, inverted, noise) on each channel. A cycle-by-cycle model built from the requirements predicts every flag.

// File: rtl/presdet_pkg.sv
package presdet_pkg;
    typedef enum logic {
        QS_SEEK    = 1'b0,
        QS_PRESENT = 1'b1
    } qual_state_e;
endpackage

// File: rtl/presdet_refdiv.sv
module presdet_refdiv #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic emit
);
    logic [DIV_LOG2-1:0] div_q;

    // advances on the falling edge so the rising-edge samplers see a settled level
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    assign emit = div_q[DIV_LOG2-1];
endmodule

// File: rtl/presdet_sync.sv
module presdet_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/presdet_qual.sv
module presdet_qual
    import presdet_pkg::*;
#(
    parameter int THRESH       = 32,
    parameter int MIN_MISMATCH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sns,
    input  logic rfb,
    output logic present
);
    localparam int CW = $clog2(THRESH + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(THRESH - 1);

    logic mis;
    logic mis_evt;
    qual_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    assign mis = sns ^ rfb;

    generate
        if (MIN_MISMATCH <= 1) begin : g_nofilt
            assign mis_evt = mis;
        end else begin : g_filt
            localparam int MW = $clog2(MIN_MISMATCH + 1);
            localparam logic [MW-1:0] MM_LAST = MW'(MIN_MISMATCH - 1);
            logic [MW-1:0] mm_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)               mm_q <= '0;
                else if (!mis)            mm_q <= '0;
                else if (mm_q != MM_LAST) mm_q <= mm_q + 1'b1;
            end
            assign mis_evt = mis && (mm_q == MM_LAST);
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= QS_SEEK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: restart, qualify, release
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            QS_SEEK: begin
                if (mis_evt) begin
                    cnt_d = '0;
                end else if (!mis) begin
                    if (cnt_q == CNT_LAST) state_d = QS_PRESENT;
                    else                   cnt_d   = cnt_q + 1'b1;
                end
            end
            QS_PRESENT: begin
                if (mis_evt) begin
                    state_d = QS_SEEK;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = QS_SEEK;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        present = (state_q == QS_PRESENT);
    end
endmodule

// File: rtl/presdet_top.sv
module presdet_top #(
    parameter int CHANNELS     = 3,
    parameter int DIV_LOG2     = 3,
    parameter int REF_PERIODS  = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int MIN_MISMATCH = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CHANNELS-1:0] sense_i,
    output logic                emit_o,
    output logic [CHANNELS-1:0] present_o
);
    localparam int THRESH = REF_PERIODS * (1 << DIV_LOG2);

    logic          emit;
    logic [CHANNELS:0] sync_q;

    presdet_refdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .emit (emit)
    );

    // reference rides in the same synchroniser so both reach the compare aligned
    presdet_sync #(.WIDTH(CHANNELS + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({emit, sense_i}),
        .q    (sync_q)
    );

    generate
        for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
            presdet_qual #(.THRESH(THRESH), .MIN_MISMATCH(MIN_MISMATCH)) u_qual (
                .clk    (clk),
                .rst_n  (rst_n),
                .sns    (sync_q[c]),
                .rfb    (sync_q[CHANNELS]),
                .present(present_o[c])
            );
        end
    endgenerate

    assign emit_o = emit;
endmodule

// File: rtl/presdet_chk.sv
module presdet_chk #(
    parameter int CHANNELS     = 3,
    parameter int DIV_LOG2     = 3,
    parameter int THRESH       = 32,
    parameter int MIN_MISMATCH = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                emit,
    input logic [CHANNELS-1:0] sns,
    input logic                rfb,
    input logic [CHANNELS-1:0] present
);
    localparam int HALF = 1 << (DIV_LOG2 - 1);
    localparam int HW   = $clog2(HALF + 1);
    localparam int RW   = $clog2(THRESH + 1);

    logic          emit_q;
    logic [HW-1:0] hcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emit_q <= 1'b0;
            hcnt_q <= '0;
        end else begin
            emit_q <= emit;
            hcnt_q <= (emit != emit_q) ? '0 : hcnt_q + 1'b1;
        end
    end

    AST_EMIT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (emit != emit_q) |-> (hcnt_q == HW'(HALF - 1))); // R1

    generate
        for (genvar c = 0; c < CHANNELS; c++) begin : g_c
            logic [RW-1:0] run_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                       run_q <= '0;
                else if (sns[c] != rfb)           run_q <= '0;
                else if (run_q != RW'(THRESH))    run_q <= run_q + 1'b1;
            end

            AST_HOLD_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
                (present[c] && (sns[c] == rfb)) |=> present[c]); // R5

            if (MIN_MISMATCH <= 1) begin : g_nf
                AST_PRESENT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
                    present[c] == (run_q == RW'(THRESH))); // R4
                AST_DROP_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
                    (sns[c] != rfb) |=> !present[c]); // R6
            end
        end
    endgenerate
endmodule

bind presdet_top presdet_chk #(
    .CHANNELS    (CHANNELS),
    .DIV_LOG2    (DIV_LOG2),
    .THRESH      (REF_PERIODS * (1 << DIV_LOG2)),
    .MIN_MISMATCH(MIN_MISMATCH)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .emit   (emit_o),
    .sns    (sync_q[CHANNELS-1:0]),
    .rfb    (sync_q[CHANNELS]),
    .present(present_o)
);

// File: tb/presdet_top_tb.sv
module presdet_top_tb;
    localparam int NCH = 3;
    localparam int AGREE_NEEDED = 32;
    localparam int WATCHDOG = 150000;

    localparam int M_ECHO = 0, M_HIGH = 1, M_LOW = 2, M_FAST = 3, M_NOISE = 4, M_INV = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] sense;
    logic emit_o, emit_f;
    logic [NCH-1:0] present_o, present_f;

    int mode [NCH];
    logic [NCH-1:0] xmask = '0;
    logic [NCH-1:0] noise = '0;
    logic tog = 1'b0;
    logic mon_en = 1'b0;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    presdet_top u_dut (
        .clk(clk), .rst_n(rst_n), .sense_i(sense), .emit_o(emit_o), .present_o(present_o)
    );

    presdet_top #(.MIN_MISMATCH(2)) u_dut_flt (
        .clk(clk), .rst_n(rst_n), .sense_i(sense), .emit_o(emit_f), .present_o(present_f)
    );

    always @(negedge clk) begin
        tog   <= ~tog;
        noise <= NCH'($urandom);
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            case (mode[c])
                M_ECHO:  sense[c] = emit_o ^ xmask[c];
                M_HIGH:  sense[c] = 1'b1 ^ xmask[c];
                M_LOW:   sense[c] = 1'b0 ^ xmask[c];
                M_FAST:  sense[c] = tog ^ xmask[c];
                M_NOISE: sense[c] = noise[c] ^ xmask[c];
                default: sense[c] = ~emit_o ^ xmask[c];
            endcase
        end
    end

    // reference model of the divider (R1)
    logic [2:0] mdiv;
    always @(negedge clk or negedge rst_n) begin
        if (!rst_n) mdiv <= '0;
        else        mdiv <= mdiv + 3'd1;
    end

    // reference model of qualification: agreement seen two rising edges later (R3)
    logic [NCH-1:0] d1, d2, mpres;
    int mcnt [NCH];
    always @(posedge clk) begin
        if (!rst_n) begin
            d1 = '1; d2 = '1; mpres = '0;
            for (int c = 0; c < NCH; c++) mcnt[c] = 0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (!d2[c]) begin
                    mcnt[c] = 0; mpres[c] = 1'b0;
                end else if (!mpres[c]) begin
                    if (mcnt[c] == AGREE_NEEDED - 1) mpres[c] = 1'b1;
                    else                            mcnt[c] = mcnt[c] + 1;
                end
            end
            d2 = d1;
            d1 = ~(sense ^ {NCH{emit_o}});
        end
    end

    always @(posedge clk) begin
        if (mon_en) begin
            tests++;
            if (emit_o !== mdiv[2]) begin
                fails++;
                $display("FAIL R1 emit_o actual=%0b expected=%0b", emit_o, mdiv[2]);
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en) begin
            for (int c = 0; c < NCH; c++) begin
                tests++;
                if (present_o[c] !== mpres[c]) begin
                    fails++;
                    $display("FAIL R3,R4,R5,R6,R7 ch%0d present actual=%0b expected=%0b",
                             c, present_o[c], mpres[c]);
                end
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic glitch(input int c, input int len);
        @(negedge clk);
        xmask[c] = 1'b1;
        repeat (len) @(negedge clk);
        xmask[c] = 1'b0;
    endtask

    initial begin
        #(WATCHDOG * 10);
        fails++;
        $display("FAIL watchdog R1..all actual=timeout expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int hi;
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) mode[c] = M_ECHO;
        cyc(4);
        chk("R2 reset present ch0", present_o[0], 1'b0);
        chk("R2 reset present ch2", present_o[2], 1'b0);
        chk("R1 reset emit", emit_o, 1'b0);
        @(posedge clk); #1 rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk("R2 present after reset", present_o[1], 1'b0);

        // R1: half the samples high over one period
        hi = 0;
        for (int i = 0; i < 8; i++) begin @(posedge clk); #2 hi += int'(emit_o); end
        chk("R1 duty four of eight", hi == 4, 1'b1);

        // R4: echo on all channels qualifies
        cyc(60);
        for (int c = 0; c < NCH; c++) chk("R4 echo qualifies", present_o[c], 1'b1);

        // R8/R9/R5: each bad pattern on ch1 while the others keep echo
        for (int m = M_HIGH; m <= M_INV; m++) begin
            mode[1] = m;
            cyc(300);
            chk("R8 bad pattern never present", present_o[1], 1'b0);
            chk("R9 ch0 unaffected", present_o[0], 1'b1);
            chk("R5 ch2 stays latched", present_o[2], 1'b1);
        end
        mode[1] = M_ECHO;

        // R6: removal drops quickly
        mode[2] = M_LOW;
        cyc(10);
        chk("R6 removal drops ch2", present_o[2], 1'b0);
        mode[2] = M_ECHO;

        // R7: glitch before threshold restarts the count
        mode[0] = M_LOW;
        cyc(20);
        mode[0] = M_ECHO;
        cyc(20);
        glitch(0, 1);
        cyc(25);
        chk("R7 count restarted", present_o[0], 1'b0);
        cyc(20);
        chk("R7 qualifies after full run", present_o[0], 1'b1);

        // R10: one-sample glitch ignored only by the filtered instance
        cyc(60);
        chk("R10 filtered ch0 present before glitch", present_f[0], 1'b1);
        glitch(0, 1);
        cyc(5);
        chk("R6 unfiltered drops on glitch", present_o[0], 1'b0);
        chk("R10 filtered ignores one-sample glitch", present_f[0], 1'b1);
        glitch(1, 2);
        cyc(6);
        chk("R10 filtered drops on two-sample mismatch", present_f[1], 1'b0);

        // random mix of modes and glitches, checked by the model every cycle
        for (int r = 0; r < 40; r++) begin
            for (int c = 0; c < NCH; c++) mode[c] = int'($urandom % 6);
            if ($urandom % 3 == 0) mode[r % NCH] = M_ECHO;
            cyc(20 + int'($urandom % 100));
            if ($urandom % 4 == 0) glitch(int'($urandom % NCH), 1);
        end

        mon_en = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule